// File: doc/BRIEF.md
# Streaming Constant Adder with Sideband Passthrough

This block is one stage of a streaming pipeline. Words arrive on an AXI4-Stream receiving port and leave on an AXI4-Stream sending port. Each outgoing word carries the incoming signed value plus a constant offset (5 by default). Every other field of the beat goes out unchanged and stays attached to its own data word: the byte-enable masks (keep and strobe), the user bits, the stream identifier, the routing destination and the end-of-frame marker. A frame is normally fifty beats. The stage does not count beats, so frames keep the length the upstream gives them and the same order.

A single register holds one beat between the two ports. When the consumer is always ready, the stage accepts and emits one beat per clock and adds one cycle of latency. When the consumer stalls, the pending beat stays on the output unchanged and the stage stops accepting input. No beat is lost or repeated. The value width can be set below the bus width. The bus is then rounded up to whole bytes. The result is sign-extended into the pad bits, and the pad bits of the input are not used.

Top module: `strm_offset_adder`

## Requirements
- R1: With a 32-bit value, out data equals in data plus 5 in two's-complement arithmetic, wrapping modulo 2^32 (0x7FFFFFFF becomes 0x80000004, 0xFFFFFFFB becomes 0).
- R2: Each output beat carries the keep (4 bits), strobe (4 bits) and last (1 bit) values of the input beat it was made from.
- R3: Each output beat carries the user (2 bits), id (5 bits) and dest (6 bits) values of the input beat it was made from.
- R4: Once output valid is high with ready low, valid stays high and every output field stays stable until a cycle in which ready is high.
- R5: Input ready is low exactly when an output beat is pending (output valid high and output ready low), and high otherwise.
- R6: With input valid and output ready both held high, a beat accepted in one cycle is presented in the next, and a 50-beat frame is fully emitted within 52 cycles.
- R7: Output beats leave in the order they were accepted, with none dropped or duplicated, so every 50-beat frame leaves as 50 beats with last set only on the 50th.
- R8: While reset is low after a clock edge, output valid is low and input ready is high.
- R9: With a 12-bit value parameter the data bus is 16 bits wide. Input bits [15:12] are ignored. Output bits [11:0] are the low 12 bits plus 5, wrapped modulo 2^12, and bits [15:12] copy bit 11 of that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | BUS_W (32) | Incoming data word |
| s_tkeep | input | BUS_W/8 (4) | Incoming byte keep mask |
| s_tstrb | input | BUS_W/8 (4) | Incoming byte strobe mask |
| s_tuser | input | USER_W (2) | Incoming user bits |
| s_tid | input | ID_W (5) | Incoming stream identifier |
| s_tdest | input | DEST_W (6) | Incoming routing destination |
| s_tlast | input | 1 | Incoming end-of-frame marker |
| s_tvalid | input | 1 | Incoming beat valid |
| s_tready | output | 1 | Stage can take a beat |
| m_tdata | output | BUS_W (32) | Outgoing data word (value plus offset) |
| m_tkeep | output | BUS_W/8 (4) | Outgoing keep mask |
| m_tstrb | output | BUS_W/8 (4) | Outgoing strobe mask |
| m_tuser | output | USER_W (2) | Outgoing user bits |
| m_tid | output | ID_W (5) | Outgoing stream identifier |
| m_tdest | output | DEST_W (6) | Outgoing routing destination |
| m_tlast | output | 1 | Outgoing end-of-frame marker |
| m_tvalid | output | 1 | Outgoing beat valid |
| m_tready | input | 1 | Consumer takes the beat |

## Verification
The only internal state is the held beat and its valid flag, and a fault in either shows at the ports within one cycle. A stuck or lost valid shows as a missing or repeated output beat on the next consumer handshake. A payload loaded on the wrong edge shows as a field that moves during a stall, or that belongs to the previous beat. Input ready that disagrees with the pending state shows in the same cycle, as an accepted beat overwriting a stalled one. The bench keeps its own queue of expected beats, so any of these faults surfaces as an order or value mismatch on the very beat involved.

// File: rtl/strm_add_pkg.sv
// Package: shared helpers for the streaming constant adder.
// Assumes widths are given in bits and are positive.
package strm_add_pkg;

    // Round a bit width up to a whole number of bytes.
    function automatic int unsigned bus_bits(input int unsigned val_bits);
        return ((val_bits + 7) / 8) * 8;
    endfunction

    // Number of byte lanes on a bus of the given width.
    function automatic int unsigned lane_count(input int unsigned val_bits);
        return bus_bits(val_bits) / 8;
    endfunction

endpackage

// File: rtl/strm_add_core.sv
// Module: combinational datapath that adds a signed constant to one word.
// Takes the low VAL_W bits of the bus word as a signed value, adds OFFSET
// modulo 2^VAL_W and sign-extends the result to the byte-rounded bus width.
// Assumes VAL_W >= 2. Bus bits above VAL_W on the input are not used.
module strm_add_core #(
    parameter int unsigned VAL_W  = 32,
    parameter int          OFFSET = 5,
    parameter int unsigned BUS_W  = strm_add_pkg::bus_bits(VAL_W)
) (
    input  logic [BUS_W-1:0] in_word,
    output logic [BUS_W-1:0] out_word
);
    localparam int unsigned PAD_W = BUS_W - VAL_W;
    localparam logic [VAL_W-1:0] OFF_V = VAL_W'(OFFSET);

    logic [VAL_W-1:0] sum_v;

    // Wrapping add of the offset on the meaningful value bits.
    always_comb begin
        sum_v = in_word[VAL_W-1:0] + OFF_V;
    end

    // Pick the output shape: plain result or sign-extended into pad bits.
    generate
        if (PAD_W == 0) begin : g_full
            assign out_word = sum_v;
        end else begin : g_pad
            assign out_word = {{PAD_W{sum_v[VAL_W-1]}}, sum_v};
        end
    endgenerate

endmodule

// File: rtl/strm_beat_reg.sv
// Module: one-entry valid/ready register stage for an opaque payload.
// Accepts when empty or when the held entry leaves in the same cycle, so it
// sustains one beat per cycle under constant downstream readiness.
// Assumes the upstream holds valid and payload until accepted.
module strm_beat_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_bits,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_bits
);
    logic         full_q;
    logic [W-1:0] bits_q;
    logic         take;

    // Space exists when empty or when the held beat drains now.
    always_comb begin
        in_ready = !full_q || out_ready;
        take     = in_valid && in_ready;
    end

    // Occupancy flag: set on accept, cleared when drained without refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (take) begin
            full_q <= 1'b1;
        end else if (out_ready) begin
            full_q <= 1'b0;
        end
    end

    // Payload capture on every accepted beat; held otherwise.
    always_ff @(posedge clk) begin
        if (take) begin
            bits_q <= in_bits;
        end
    end

    assign out_valid = full_q;
    assign out_bits  = bits_q;

endmodule

// File: rtl/strm_offset_adder.sv
// Module: AXI4-Stream stage adding a constant to each data word while copying
// keep, strobe, user, id, dest and last from the same beat.
// Assumes synchronous active-low reset and upstream AXI4-Stream compliance.
module strm_offset_adder #(
    parameter int unsigned VAL_W  = 32,
    parameter int          OFFSET = 5,
    parameter int unsigned USER_W = 2,
    parameter int unsigned ID_W   = 5,
    parameter int unsigned DEST_W = 6,
    parameter int unsigned BUS_W  = strm_add_pkg::bus_bits(VAL_W),
    parameter int unsigned LANES  = BUS_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  s_tdata,
    input  logic [LANES-1:0]  s_tkeep,
    input  logic [LANES-1:0]  s_tstrb,
    input  logic [USER_W-1:0] s_tuser,
    input  logic [ID_W-1:0]   s_tid,
    input  logic [DEST_W-1:0] s_tdest,
    input  logic              s_tlast,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [BUS_W-1:0]  m_tdata,
    output logic [LANES-1:0]  m_tkeep,
    output logic [LANES-1:0]  m_tstrb,
    output logic [USER_W-1:0] m_tuser,
    output logic [ID_W-1:0]   m_tid,
    output logic [DEST_W-1:0] m_tdest,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready
);
    localparam int unsigned SIDE_W = 2 * LANES + USER_W + ID_W + DEST_W + 1;
    localparam int unsigned PAY_W  = BUS_W + SIDE_W;

    logic [BUS_W-1:0] sum_word;
    logic [PAY_W-1:0] pay_in;
    logic [PAY_W-1:0] pay_out;

    strm_add_core #(
        .VAL_W (VAL_W),
        .OFFSET(OFFSET),
        .BUS_W (BUS_W)
    ) u_core (
        .in_word (s_tdata),
        .out_word(sum_word)
    );

    // Bundle modified data with its untouched sideband fields.
    always_comb begin
        pay_in = {s_tlast, s_tdest, s_tid, s_tuser, s_tstrb, s_tkeep, sum_word};
    end

    strm_beat_reg #(
        .W(PAY_W)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (s_tvalid),
        .in_ready (s_tready),
        .in_bits  (pay_in),
        .out_valid(m_tvalid),
        .out_ready(m_tready),
        .out_bits (pay_out)
    );

    // Split the held payload back onto the output fields.
    always_comb begin
        {m_tlast, m_tdest, m_tid, m_tuser, m_tstrb, m_tkeep, m_tdata} = pay_out;
    end

endmodule

// File: rtl/strm_add_chk.sv
// Checker: handshake and sideband properties of strm_offset_adder.
// Observes ports only; bound to every instance of the top module.
module strm_add_chk #(
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned LANES  = 4,
    parameter int unsigned USER_W = 2,
    parameter int unsigned ID_W   = 5,
    parameter int unsigned DEST_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LANES-1:0]  s_tkeep,
    input logic [LANES-1:0]  s_tstrb,
    input logic [USER_W-1:0] s_tuser,
    input logic [ID_W-1:0]   s_tid,
    input logic [DEST_W-1:0] s_tdest,
    input logic              s_tlast,
    input logic              s_tvalid,
    input logic              s_tready,
    input logic [BUS_W-1:0]  m_tdata,
    input logic [LANES-1:0]  m_tkeep,
    input logic [LANES-1:0]  m_tstrb,
    input logic [USER_W-1:0] m_tuser,
    input logic [ID_W-1:0]   m_tid,
    input logic [DEST_W-1:0] m_tdest,
    input logic              m_tlast,
    input logic              m_tvalid,
    input logic              m_tready
);
    logic       s_fire;
    logic       m_fire;
    logic [1:0] occ;
    logic       rst_edge;

    assign s_fire = s_tvalid && s_tready;
    assign m_fire = m_tvalid && m_tready;

    // Independent count of beats inside the stage.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= 2'd0;
        else        occ <= occ + {1'b0, s_fire} - {1'b0, m_fire};
    end

    // Remember that an edge occurred while reset was low.
    always_ff @(posedge clk) begin
        rst_edge <= !rst_n;
    end

    // R2
    mask_last_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_fire |=> (m_tvalid && m_tkeep == $past(s_tkeep) &&
                    m_tstrb == $past(s_tstrb) && m_tlast == $past(s_tlast)));

    // R3
    route_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_fire |=> (m_tuser == $past(s_tuser) && m_tid == $past(s_tid) &&
                    m_tdest == $past(s_tdest)));

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) &&
            $stable(m_tkeep) && $stable(m_tstrb) && $stable(m_tuser) &&
            $stable(m_tid) && $stable(m_tdest) && $stable(m_tlast)));

    // R5
    backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready == !(m_tvalid && !m_tready));

    // R7
    no_loss_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ == {1'b0, m_tvalid});

    // R8
    always @(negedge clk) begin
        if (rst_edge && !rst_n) begin
            reset_state_chk: assert (!m_tvalid && s_tready);
        end
    end

endmodule

bind strm_offset_adder strm_add_chk #(
    .BUS_W (BUS_W),
    .LANES (LANES),
    .USER_W(USER_W),
    .ID_W  (ID_W),
    .DEST_W(DEST_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_tkeep (s_tkeep),
    .s_tstrb (s_tstrb),
    .s_tuser (s_tuser),
    .s_tid   (s_tid),
    .s_tdest (s_tdest),
    .s_tlast (s_tlast),
    .s_tvalid(s_tvalid),
    .s_tready(s_tready),
    .m_tdata (m_tdata),
    .m_tkeep (m_tkeep),
    .m_tstrb (m_tstrb),
    .m_tuser (m_tuser),
    .m_tid   (m_tid),
    .m_tdest (m_tdest),
    .m_tlast (m_tlast),
    .m_tvalid(m_tvalid),
    .m_tready(m_tready)
);

// File: tb/test_strm_offset_adder.sv
module test_strm_offset_adder;

    typedef struct packed {
        logic        last;
        logic [5:0]  dest;
        logic [4:0]  id;
        logic [1:0]  user;
        logic [3:0]  strb;
        logic [3:0]  keep;
        logic [31:0] data;
    } beat_t;

    localparam int FRAME = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [31:0] s_tdata = '0;
    logic [3:0]  s_tkeep = '0, s_tstrb = '0;
    logic [1:0]  s_tuser = '0;
    logic [4:0]  s_tid = '0;
    logic [5:0]  s_tdest = '0;
    logic        s_tlast = 1'b0, s_tvalid = 1'b0, s_tready;
    logic [31:0] m_tdata;
    logic [3:0]  m_tkeep, m_tstrb;
    logic [1:0]  m_tuser;
    logic [4:0]  m_tid;
    logic [5:0]  m_tdest;
    logic        m_tlast, m_tvalid;
    logic        m_tready = 1'b0;

    strm_offset_adder i_strm_offset_adder (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tstrb(s_tstrb), .s_tuser(s_tuser),
        .s_tid(s_tid), .s_tdest(s_tdest), .s_tlast(s_tlast), .s_tvalid(s_tvalid),
        .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tstrb(m_tstrb), .m_tuser(m_tuser),
        .m_tid(m_tid), .m_tdest(m_tdest), .m_tlast(m_tlast), .m_tvalid(m_tvalid),
        .m_tready(m_tready)
    );

    // Narrow-value instance: 12-bit value on a 16-bit bus, always ready.
    logic [15:0] n_in = '0;
    logic [15:0] n_out;
    logic        n_valid = 1'b0, n_sready, n_mvalid;
    logic [1:0]  n_keep, n_strb;
    logic [1:0]  n_user;
    logic [4:0]  n_id;
    logic [5:0]  n_dest;
    logic        n_last;

    strm_offset_adder #(.VAL_W(12)) i_strm_offset_adder_narrow (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(n_in), .s_tkeep(2'b11), .s_tstrb(2'b11), .s_tuser(2'b00),
        .s_tid(5'd0), .s_tdest(6'd0), .s_tlast(1'b0), .s_tvalid(n_valid),
        .s_tready(n_sready),
        .m_tdata(n_out), .m_tkeep(n_keep), .m_tstrb(n_strb), .m_tuser(n_user),
        .m_tid(n_id), .m_tdest(n_dest), .m_tlast(n_last), .m_tvalid(n_mvalid),
        .m_tready(1'b1)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    beat_t src_q[$];
    beat_t exp_q[$];
    beat_t cur;
    bit    fired = 1'b0;
    bit    hold_pend = 1'b0;
    beat_t held;
    int    out_cnt = 0;
    int    last_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic beat_t out_beat();
        beat_t b;
        b = '{m_tlast, m_tdest, m_tid, m_tuser, m_tstrb, m_tkeep, m_tdata};
        return b;
    endfunction

    function automatic beat_t expect_of(input beat_t b);
        beat_t r;
        r = b;
        r.data = b.data + 32'd5;
        return r;
    endfunction

    function automatic logic [15:0] narrow_exp(input logic [15:0] x);
        logic [11:0] s;
        s = x[11:0] + 12'd5;
        return {{4{s[11]}}, s};
    endfunction

    task automatic make_frame(input int fid, input bit corners);
        for (int i = 0; i < FRAME; i++) begin
            beat_t b;
            b.data = $urandom;
            b.keep = 4'($urandom);
            b.strb = 4'($urandom);
            b.user = 2'($urandom);
            b.id   = 5'(fid);
            b.dest = 6'($urandom);
            b.last = (i == FRAME - 1);
            if (corners) begin
                case (i)
                    0: b.data = 32'h7FFF_FFFF;
                    1: b.data = 32'hFFFF_FFFB;
                    2: b.data = 32'h8000_0000;
                    3: b.data = 32'hFFFF_FFFF;
                    default: ;
                endcase
            end
            src_q.push_back(b);
        end
    endtask

    // One bench cycle: drive at negedge, settle, then check and score.
    task automatic step(input int vprob, input int rprob, output bit mf);
        @(negedge clk);
        if (hold_pend) begin
            chk(m_tvalid && out_beat() == held, "R4", "stalled beat changed",
                64'(out_beat()), 64'(held));
        end
        if (!s_tvalid || fired) begin
            if (src_q.size() > 0 && ($urandom % 100) < vprob) begin
                cur = src_q.pop_front();
                {s_tlast, s_tdest, s_tid, s_tuser, s_tstrb, s_tkeep, s_tdata} = cur;
                s_tvalid = 1'b1;
            end else begin
                s_tvalid = 1'b0;
            end
        end
        m_tready = (($urandom % 100) < rprob);
        #1;
        chk(s_tready == !(m_tvalid && !m_tready), "R5", "input ready",
            64'(s_tready), 64'(!(m_tvalid && !m_tready)));
        mf = m_tvalid && m_tready;
        if (mf) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected output beat", 64'(out_beat()), 64'd0);
            end else begin
                beat_t e;
                beat_t a;
                e = exp_q.pop_front();
                a = out_beat();
                chk(a.data == e.data, "R1", "data", 64'(a.data), 64'(e.data));
                chk(a.keep == e.keep && a.strb == e.strb && a.last == e.last,
                    "R2", "keep/strb/last", 64'({a.keep, a.strb, a.last}),
                    64'({e.keep, e.strb, e.last}));
                chk(a.user == e.user && a.id == e.id && a.dest == e.dest,
                    "R3", "user/id/dest", 64'({a.user, a.id, a.dest}),
                    64'({e.user, e.id, e.dest}));
            end
            out_cnt++;
            if (m_tlast) last_cnt++;
        end
        fired = s_tvalid && s_tready;
        if (fired) exp_q.push_back(expect_of(cur));
        hold_pend = m_tvalid && !m_tready;
        held = out_beat();
    endtask

    task automatic drain(input int vprob, input int rprob);
        bit mf;
        for (int c = 0; c < 5000; c++) begin
            if (src_q.size() == 0 && exp_q.size() == 0 && !s_tvalid) break;
            step(vprob, rprob, mf);
        end
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "R7", "watchdog expired", 64'(out_cnt), 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit mf;
        int fires;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R8: reset state at the ports.
        chk(!m_tvalid && s_tready, "R8", "reset valid/ready",
            64'({m_tvalid, s_tready}), 64'({1'b0, 1'b1}));
        rst_n = 1'b1;

        // R9: narrow value with garbage pad bits; output one cycle later.
        begin
            logic [15:0] vec [4];
            vec[0] = 16'hF7FF; vec[1] = 16'h0FFF; vec[2] = 16'hA123; vec[3] = 16'h5800;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                n_in = vec[i];
                n_valid = 1'b1;
                @(negedge clk);
                n_valid = 1'b0;
                chk(n_mvalid && n_out == narrow_exp(vec[i]), "R9", "narrow result",
                    64'(n_out), 64'(narrow_exp(vec[i])));
            end
        end

        // R6: full-rate frame with corner values; 50 outputs within 52 cycles.
        make_frame(1, 1'b1);
        fires = 0;
        for (int c = 0; c < 52; c++) begin
            step(100, 100, mf);
            if (mf) fires++;
        end
        chk(fires == FRAME, "R6", "beats out at full rate", 64'(fires), 64'(FRAME));
        s_tvalid = 1'b0;
        drain(100, 100);

        // Random valid and ready over several frames.
        for (int f = 2; f < 6; f++) make_frame(f, 1'b0);
        drain(60, 50);

        // Heavy stalls: consumer mostly not ready.
        make_frame(6, 1'b0);
        for (int c = 0; c < 30; c++) step(100, 10, mf);
        drain(90, 30);

        @(negedge clk);
        #1;
        chk(!m_tvalid, "R7", "stage empty after drain", 64'(m_tvalid), 64'd0);
        chk(out_cnt == 6 * FRAME, "R7", "total beats", 64'(out_cnt), 64'(6 * FRAME));
        chk(last_cnt == 6, "R7", "frame ends", 64'(last_cnt), 64'd6);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule